// File: doc/BRIEF.md
# Commutation-Event Channel Configuration Shadow

This block sits in the control path of a timer that drives several complementary output pairs. Each channel has three settings: a three-bit output mode, an enable for the main output and an enable for the complementary output. Software writes these settings through a simple per-channel write port into a staging (preload) copy. The waveform logic never sees the staging copy. It sees only the live copy. When a commutation event occurs, every channel's staging copy moves into its live copy on the same clock edge. This lets a multi-channel step, such as the next state of a six-step drive, be prepared ahead of time and applied in one atomic step.

A commutation event starts in one of two ways. The first is a self-clearing software generate strobe. The second, when the hardware source is selected, is a rising edge on an asynchronous trigger pin; that pin is synchronised and edge-detected on the block clock. Each event sets a sticky flag, and only software clears it. The flag drives an interrupt output and a DMA request output, each behind its own enable. When staging is switched off, writes reach the live copy directly and events leave the live copy alone. Two of the mode codes force the reference level low or high. The block decodes them from the live copy, so a forced level appears only once the event that loads it has occurred.

Top module: `comm_shadow_ctrl`

## Requirements
- R1: With staging enabled (`cfg_preload_en`=1), a write updates only the channel's staging copy. The live outputs `act_mode`, `act_main_en` and `act_comp_en` stay unchanged until a commutation event.
- R2: At a commutation event with staging enabled, all channels load their staging copies into their live copies on the same clock edge. This is the edge that ends the cycle in which `evt_pulse` is high.
- R3: When `sw_gen` is sampled high on one clock edge, `evt_pulse` is high for exactly the next cycle and then clears without further action. The live copies change on the following edge.
- R4: When `cfg_hw_src_en`=1, a rising edge of `trg_in` causes an event. If `trg_in` goes high before edge k, `evt_pulse` is high between edges k+1 and k+2, and the live copies change at edge k+2. A falling edge of `trg_in` causes no event. With `cfg_hw_src_en`=0, `trg_in` causes no event.
- R5: `evt_flag` is set by every event and stays set until `flag_clr` is sampled high. If an event and `flag_clr` occur in the same cycle, the flag ends up set. `evt_flag` is 0 after reset.
- R6: `irq` equals `evt_flag` AND `cfg_irq_en`. `dma_req` equals `evt_flag` AND `cfg_dma_en`.
- R7: With staging disabled (`cfg_preload_en`=0), a write reaches the live copy on the edge that samples it, and a commutation event leaves the live copies unchanged. The event still sets `evt_flag`.
- R8: For channel i, `ref_forced[i]` is 1 exactly when its live mode is 3'b100 (forced low) or 3'b101 (forced high). `ref_level[i]` is 1 only for 3'b101. Because both are decoded from the live copy, a forced mode takes effect only when it is loaded.
- R9: A software strobe and a trigger edge that fall in the same cycle produce a single event, so `evt_pulse` is high for one cycle only.
- R10: After reset, every live and staging copy is all zeros: mode 3'b000 with both enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one channel's settings |
| wr_ch | input | CH_W | Channel index of the write |
| wr_mode | input | 3 | Output mode to write |
| wr_main_en | input | 1 | Main-output enable to write |
| wr_comp_en | input | 1 | Complementary-output enable to write |
| cfg_preload_en | input | 1 | 1: stage writes until an event; 0: write straight to the live copy |
| cfg_hw_src_en | input | 1 | Lets a trigger rising edge cause an event |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_dma_en | input | 1 | DMA request enable |
| sw_gen | input | 1 | Software generate strobe |
| flag_clr | input | 1 | Software clear of the event flag |
| trg_in | input | 1 | Asynchronous hardware trigger |
| act_mode | output | NUM_CH*3 | Live mode per channel; channel i at bits [3i+2:3i] |
| act_main_en | output | NUM_CH | Live main-output enables |
| act_comp_en | output | NUM_CH | Live complementary-output enables |
| ref_forced | output | NUM_CH | Live mode forces the reference level |
| ref_level | output | NUM_CH | Forced reference level |
| evt_pulse | output | 1 | One-cycle commutation event |
| evt_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench uses the defaults: three channels and a two-stage synchroniser. With three channels, one strobe can be seen moving several channels that hold different staged settings, and a two-bit channel index holds an unused value. With a two-stage synchroniser, the trigger-to-load latency is three edges, so a trigger and a strobe issued one cycle apart land in the same event cycle. The vector walk moves the forced-low, forced-high and ordinary modes across all channels. Directed cases then cover bypass, the trigger source gate, falling edges, coincident sources and clear-versus-set.

// File: rtl/comm_pkg.sv
package comm_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_FORCE_LO = 3'b100;
  localparam mode_t MODE_FORCE_HI = 3'b101;

  typedef struct packed {
    mode_t mode;
    logic  main_en;
    logic  comp_en;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{mode: '0, main_en: 1'b0, comp_en: 1'b0};
endpackage

// File: rtl/comm_trig_sync.sv
module comm_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trg_async,
  output logic rise_o
);
  localparam int LAST = STAGES;

  // sh[0..STAGES-1] synchroniser, sh[STAGES] holds the previous synchronised level
  logic [LAST:0] sh_q, sh_d;

  generate
    for (genvar s = 0; s <= LAST; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb sh_d[s] = trg_async;
      end else begin : g_next
        always_comb sh_d[s] = sh_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/comm_evt_ctrl.sv
module comm_evt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_gen,
  input  logic hw_rise,
  input  logic hw_src_en,
  input  logic flag_clr,
  input  logic irq_en,
  input  logic dma_en,
  output logic evt,
  output logic flag,
  output logic irq,
  output logic dma_req
);
  logic gen_q, gen_d;
  logic flag_q, flag_d;
  logic hw_evt;

  // generate bit: set by the strobe, clears itself after one cycle
  always_comb gen_d = sw_gen;

  always_comb hw_evt = hw_src_en & hw_rise;

  // both sources merge into one event
  always_comb evt = gen_q | hw_evt;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (evt)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      gen_q  <= gen_d;
      flag_q <= flag_d;
    end
  end

  assign flag    = flag_q;
  assign irq     = flag_q & irq_en;
  assign dma_req = flag_q & dma_en;

  AST_GEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && !sw_gen) |=> !gen_q); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !evt) |=> !flag); // R5
  AST_HW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_src_en && !gen_q) |-> !evt); // R4
endmodule

// File: rtl/comm_chan_shadow.sv
module comm_chan_shadow
  import comm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  chan_cfg_t wr_cfg,
  input  logic      preload_en,
  input  logic      evt,
  output chan_cfg_t act,
  output logic      forced,
  output logic      level
);
  chan_cfg_t pre_q, pre_d;
  chan_cfg_t act_q, act_d;
  logic      act_ld;

  always_comb pre_d = wr_hit ? wr_cfg : pre_q;

  always_comb begin
    act_d  = act_q;
    act_ld = 1'b0;
    if (preload_en) begin
      if (evt) begin
        act_d  = pre_q;
        act_ld = 1'b1;
      end
    end else if (wr_hit) begin
      act_d  = wr_cfg;
      act_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= CFG_RESET;
      act_q <= CFG_RESET;
    end else begin
      if (wr_hit) pre_q <= pre_d;
      if (act_ld) act_q <= act_d;
    end
  end

  assign act    = act_q;
  assign forced = (act_q.mode == MODE_FORCE_LO) || (act_q.mode == MODE_FORCE_HI);
  assign level  = (act_q.mode == MODE_FORCE_HI);

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en ? !evt : !wr_hit) |=> $stable(act)); // R1
  AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && evt) |=> act == $past(pre_q)); // R2
  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && wr_hit) |=> act == $past(wr_cfg)); // R7
  AST_FORCE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(act) |-> $stable(forced) && $stable(level)); // R8
endmodule

// File: rtl/comm_shadow_ctrl.sv
module comm_shadow_ctrl
  import comm_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [MODE_W-1:0]        wr_mode,
  input  logic                     wr_main_en,
  input  logic                     wr_comp_en,
  input  logic                     cfg_preload_en,
  input  logic                     cfg_hw_src_en,
  input  logic                     cfg_irq_en,
  input  logic                     cfg_dma_en,
  input  logic                     sw_gen,
  input  logic                     flag_clr,
  input  logic                     trg_in,
  output logic [NUM_CH*MODE_W-1:0] act_mode,
  output logic [NUM_CH-1:0]        act_main_en,
  output logic [NUM_CH-1:0]        act_comp_en,
  output logic [NUM_CH-1:0]        ref_forced,
  output logic [NUM_CH-1:0]        ref_level,
  output logic                     evt_pulse,
  output logic                     evt_flag,
  output logic                     irq,
  output logic                     dma_req
);
  logic      hw_rise;
  logic      evt;
  chan_cfg_t wr_cfg;

  always_comb wr_cfg = '{mode: wr_mode, main_en: wr_main_en, comp_en: wr_comp_en};

  comm_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .trg_async (trg_in),
    .rise_o    (hw_rise)
  );

  comm_evt_ctrl i_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_gen    (sw_gen),
    .hw_rise   (hw_rise),
    .hw_src_en (cfg_hw_src_en),
    .flag_clr  (flag_clr),
    .irq_en    (cfg_irq_en),
    .dma_en    (cfg_dma_en),
    .evt       (evt),
    .flag      (evt_flag),
    .irq       (irq),
    .dma_req   (dma_req)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_cfg_t act_c;
      logic      hit_c;

      always_comb hit_c = wr_en && (wr_ch == CH_W'(c));

      comm_chan_shadow i_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (hit_c),
        .wr_cfg     (wr_cfg),
        .preload_en (cfg_preload_en),
        .evt        (evt),
        .act        (act_c),
        .forced     (ref_forced[c]),
        .level      (ref_level[c])
      );

      assign act_mode[c*MODE_W +: MODE_W] = act_c.mode;
      assign act_main_en[c]               = act_c.main_en;
      assign act_comp_en[c]               = act_c.comp_en;
    end
  endgenerate

  assign evt_pulse = evt;

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && !sw_gen) |=> !evt_pulse); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_flag |-> !irq && !dma_req); // R6
endmodule

// File: tb/test_comm_shadow_ctrl.sv
`timescale 1ns/1ps
module test_comm_shadow_ctrl;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_main_en, wr_comp_en;
  logic [1:0] wr_ch;
  logic [2:0] wr_mode;
  logic cfg_preload_en, cfg_hw_src_en, cfg_irq_en, cfg_dma_en;
  logic sw_gen, flag_clr, trg_in;
  logic [NCH*3-1:0] act_mode;
  logic [NCH-1:0] act_main_en, act_comp_en, ref_forced, ref_level;
  logic evt_pulse, evt_flag, irq, dma_req;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model: {mode, main, comp} per channel
  logic [4:0] pre_m [NCH];
  logic [4:0] act_m [NCH];

  always #4 clk = ~clk;

  comm_shadow_ctrl i_comm_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_mode(wr_mode),
    .wr_main_en(wr_main_en), .wr_comp_en(wr_comp_en),
    .cfg_preload_en(cfg_preload_en), .cfg_hw_src_en(cfg_hw_src_en),
    .cfg_irq_en(cfg_irq_en), .cfg_dma_en(cfg_dma_en), .sw_gen(sw_gen),
    .flag_clr(flag_clr), .trg_in(trg_in), .act_mode(act_mode),
    .act_main_en(act_main_en), .act_comp_en(act_comp_en),
    .ref_forced(ref_forced), .ref_level(ref_level), .evt_pulse(evt_pulse),
    .evt_flag(evt_flag), .irq(irq), .dma_req(dma_req)
  );

  // vector: {ch[1:0], mode[2:0], main, comp, exp_forced, exp_level}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd1, 3'b101, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd2, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'b101, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd0, 3'b101, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd2, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [14:0] live_bus();
    return {act_mode, act_main_en, act_comp_en};
  endfunction

  function automatic logic [14:0] model_bus();
    logic [8:0] m;
    logic [2:0] a, c;
    for (int i = 0; i < NCH; i++) begin
      m[i*3 +: 3] = act_m[i][4:2];
      a[i]        = act_m[i][1];
      c[i]        = act_m[i][0];
    end
    return {m, a, c};
  endfunction

  task automatic chk_live(input string req);
    chk(live_bus() == model_bus(), req, 32'(live_bus()), 32'(model_bus()));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_ch(input logic [1:0] ch, input logic [2:0] md,
                          input logic mn, input logic cp);
    wr_en = 1'b1; wr_ch = ch; wr_mode = md; wr_main_en = mn; wr_comp_en = cp;
    tick();
    wr_en = 1'b0;
    pre_m[ch] = {md, mn, cp};
    if (!cfg_preload_en) act_m[ch] = {md, mn, cp};
  endtask

  // strobe, check the pulse cycle, then the load cycle
  task automatic strobe(input string req);
    sw_gen = 1'b1;
    tick();
    sw_gen = 1'b0;
    chk(evt_pulse == 1'b1, "R3 pulse", 32'(evt_pulse), 1);
    chk_live({req, " before load"});
    tick();
    if (cfg_preload_en) for (int i = 0; i < NCH; i++) act_m[i] = pre_m[i];
    chk(evt_pulse == 1'b0, "R3 self clear", 32'(evt_pulse), 0);
    chk_live(req);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_mode = '0; wr_main_en = 1'b0;
    wr_comp_en = 1'b0; cfg_preload_en = 1'b1; cfg_hw_src_en = 1'b0;
    cfg_irq_en = 1'b0; cfg_dma_en = 1'b0; sw_gen = 1'b0; flag_clr = 1'b0;
    trg_in = 1'b0;
    for (int i = 0; i < NCH; i++) begin pre_m[i] = '0; act_m[i] = '0; end
    repeat (3) tick();
    // R10 reset state
    chk_live("R10 reset live");
    chk(ref_forced == '0, "R8 reset forced", 32'(ref_forced), 0);
    chk(evt_flag == 1'b0, "R5 reset flag", 32'(evt_flag), 0);
    rst_n = 1'b1;
    tick();
    // R10 staging is zero too: a bare event keeps everything zero
    strobe("R10 reset staging");

    // vector walk: R1 staging, R2 atomic load, R8 forced decode
    for (int v = 0; v < 8; v++) begin
      logic [8:0] e;
      logic pf, pl;
      e  = VEC[v];
      pf = ref_forced[e[8:7]];
      pl = ref_level[e[8:7]];
      write_ch(e[8:7], e[6:4], e[3], e[2]);
      tick();
      chk_live("R1 staged only");
      chk({ref_forced[e[8:7]], ref_level[e[8:7]]} == {pf, pl}, "R8 not before load",
          32'({ref_forced[e[8:7]], ref_level[e[8:7]]}), 32'({pf, pl}));
      if (v % 2 == 1) write_ch(2'((e[8:7] + 1) % 3), 3'(v), e[2], e[3]);
      strobe("R2 atomic load");
      chk({ref_forced[e[8:7]], ref_level[e[8:7]]} == e[1:0], "R8 forced decode",
          32'({ref_forced[e[8:7]], ref_level[e[8:7]]}), 32'(e[1:0]));
    end

    // R5 sticky flag, clear, set-wins
    chk(evt_flag == 1'b1, "R5 sticky", 32'(evt_flag), 1);
    cfg_irq_en = 1'b1; cfg_dma_en = 1'b0;
    #1;
    chk(irq == 1'b1 && dma_req == 1'b0, "R6 irq only", 32'({irq, dma_req}), 2);
    cfg_irq_en = 1'b0; cfg_dma_en = 1'b1;
    #1;
    chk(irq == 1'b0 && dma_req == 1'b1, "R6 dma only", 32'({irq, dma_req}), 1);
    cfg_irq_en = 1'b1;
    clear_flag();
    chk(evt_flag == 1'b0, "R5 cleared", 32'(evt_flag), 0);
    chk(irq == 1'b0 && dma_req == 1'b0, "R6 gated by flag", 32'({irq, dma_req}), 0);
    sw_gen = 1'b1;
    tick();
    sw_gen = 1'b0; flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk(evt_flag == 1'b1, "R5 set wins over clear", 32'(evt_flag), 1);
    for (int i = 0; i < NCH; i++) act_m[i] = pre_m[i];
    clear_flag();

    // R4 trigger ignored when hardware source is off
    write_ch(2'd1, 3'b101, 1'b1, 1'b0);
    trg_in = 1'b1;
    repeat (5) tick();
    chk_live("R4 source off");
    chk(evt_flag == 1'b0, "R4 source off flag", 32'(evt_flag), 0);
    // falling edge does nothing
    cfg_hw_src_en = 1'b1;
    trg_in = 1'b0;
    repeat (4) tick();
    chk_live("R4 falling edge");
    chk(evt_flag == 1'b0, "R4 falling flag", 32'(evt_flag), 0);
    // rising edge with source on: pulse in window k+1..k+2, load at k+2
    trg_in = 1'b1;
    tick();
    chk(evt_pulse == 1'b0, "R4 latency early", 32'(evt_pulse), 0);
    tick();
    chk(evt_pulse == 1'b1, "R4 pulse", 32'(evt_pulse), 1);
    chk_live("R4 before load");
    tick();
    for (int i = 0; i < NCH; i++) act_m[i] = pre_m[i];
    chk_live("R4 loaded");
    chk(evt_pulse == 1'b0, "R4 single pulse", 32'(evt_pulse), 0);
    trg_in = 1'b0;
    repeat (3) tick();
    clear_flag();

    // R9 coincident strobe and trigger edge -> one event
    begin
      int cnt;
      cnt = 0;
      trg_in = 1'b1;
      tick();
      sw_gen = 1'b1;
      tick();
      sw_gen = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (evt_pulse) cnt++;
        tick();
      end
      chk(cnt == 1, "R9 merged event", 32'(cnt), 1);
      trg_in = 1'b0;
      cfg_hw_src_en = 1'b0;
      repeat (3) tick();
      clear_flag();
    end

    // R7 bypass: direct write, event leaves live copy alone
    cfg_preload_en = 1'b0;
    write_ch(2'd2, 3'b100, 1'b0, 1'b1);
    chk_live("R7 direct write");
    chk(ref_forced[2] == 1'b1 && ref_level[2] == 1'b0, "R8 bypass forced",
        32'({ref_forced[2], ref_level[2]}), 2);
    cfg_preload_en = 1'b1;
    write_ch(2'd0, 3'b110, 1'b1, 1'b1);
    cfg_preload_en = 1'b0;
    strobe("R7 event ignored");
    chk(evt_flag == 1'b1, "R7 flag still set", 32'(evt_flag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule